// File: doc/BRIEF.md
# Fan fault and blast supervisor

This block gathers the fault sources of a dual fan controller into one latched 8-bit fault register and drives the enable of an open-drain fault pull-down. Fault sources are the overflow requests of the two tachometer counters, change-of-state events on four general purpose pins, a blast event, and a serial-access inactivity timeout. Software clears every latched fault at once by writing the fault register. The written byte is discarded, so the strobe carries no data.

A blast forces both fan DAC codes to full scale. A blast starts when the blast pin is high in the first cycle after reset is released, or when the pin falls from high to low at any later time. While the blast pin is high, a watchdog counts base ticks of the oscillator since the last serial access. When the count reaches its limit, the watchdog forces a blast and latches the timer fault. The block also makes the pull-down drive for each general purpose pin. A pin that is programmed low and has blinking enabled toggles its pull-down slowly, at about 1.5 Hz with the default parameters.

All timing is counted in `tick` pulses, which are one-cycle enables at the 50 kHz base rate. The two periods are parameters: `TIMEOUT_TICKS` (default 4,500,000, about 90 s) and `BLINK_HALF_TICKS` (default 16,667).

Top module: `fan_fault_supervisor`

## Requirements
- R1: While `rst_n` is low and in the cycles after its release (blast pin low), `fault_reg` reads 0x00 and `blast_active` is low. The fault bit positions are: bit 7 tach A, bit 6 tach B, bit 5 blast, bit 4 timer, bits 3..0 change fault of GPIO 3..0.
- R2: A cycle with `fault_wr` high clears all eight fault bits and `blast_active` at the next edge. Any event arriving in that same cycle is dropped.
- R3: If `blast_pin` is high in the first clock cycle after `rst_n` rises, bit 5 and `blast_active` are set at that edge.
- R4: A high-to-low change of `blast_pin` after reset sets bit 5 and `blast_active` at the edge where the low level is first sampled. A rising edge of `blast_pin` does nothing.
- R5: While `blast_active` is high, `dac_a_drive` and `dac_b_drive` are all ones. Otherwise they equal `dac_a_code` and `dac_b_code`.
- R6: While `blast_pin` is high, the block counts `tick` cycles that have no `access_pulse`. A cycle with `access_pulse` high restarts the count from zero. On the `TIMEOUT_TICKS`-th such tick, bit 4 and `blast_active` are set. While `blast_pin` is low, the count is held at zero and no timeout occurs.
- R7: `tach_ovf[1]` sets bit 7 and `tach_ovf[0]` sets bit 6, and the bits stay set after the request goes away. A request that is still present after a clear sets its bit again on the cycle after the clear.
- R8: While `gpio_flt_en[i]` is low, the reference of pin i follows `gpio_pin[i]`. While it is high, a difference between the pin and its reference sets bit i. A clear reloads every reference from the current pin levels.
- R9: `fault_pin_en` is high while `rst_n` is low or any fault bit is set, and low otherwise.
- R10: `gpio_pd[i]` is low when `gpio_reg[i]` is high. When `gpio_reg[i]` is low, `gpio_pd[i]` is high if blinking is off. If `gpio_blink_en[i]` is high, it follows a shared blink phase that starts on after reset and inverts every `BLINK_HALF_TICKS` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | One-cycle base-rate enable (50 kHz) |
| blast_pin | input | 1 | Synchronised blast pin level |
| access_pulse | input | 1 | Pulse on every serial access to this device |
| fault_wr | input | 1 | Write strobe of the fault register (clears faults) |
| tach_ovf | input | 2 | Overflow fault requests, bit 1 tach A, bit 0 tach B |
| gpio_pin | input | 4 | Synchronised GPIO pin levels |
| gpio_flt_en | input | 4 | Per-pin change fault enables |
| gpio_blink_en | input | 4 | Per-pin blink enables |
| gpio_reg | input | 4 | Per-pin output register bits (low turns the pull-down on) |
| dac_a_code | input | DAC_W | Programmed code of DAC A |
| dac_b_code | input | DAC_W | Programmed code of DAC B |
| fault_reg | output | 8 | Latched fault register |
| fault_pin_en | output | 1 | Enable of the fault pull-down |
| blast_active | output | 1 | Blast override in force |
| gpio_pd | output | 4 | GPIO pull-down drive |
| dac_a_drive | output | DAC_W | Code applied to DAC A |
| dac_b_drive | output | DAC_W | Code applied to DAC B |

## Verification
The hardest conditions to reach are the watchdog timeout and the blast at reset release. The default timeout is millions of ticks, and the reset-time blast needs the pin already high while reset is low. The bench therefore sets a short timeout and gives `tick` only in chosen cycles. This places the timeout, and a restart one tick short of it, on exact tick counts. It then applies reset a second time with the blast pin held high. GPIO references across clears are exercised by random pin, enable and clear patterns checked against a bench model.

// File: rtl/fan_fault_supervisor.sv
module fan_fault_supervisor #(
  parameter int unsigned TIMEOUT_TICKS    = 4_500_000,
  parameter int unsigned BLINK_HALF_TICKS = 16_667,
  parameter int unsigned DAC_W            = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             blast_pin,
  input  logic             access_pulse,
  input  logic             fault_wr,
  input  logic [1:0]       tach_ovf,
  input  logic [3:0]       gpio_pin,
  input  logic [3:0]       gpio_flt_en,
  input  logic [3:0]       gpio_blink_en,
  input  logic [3:0]       gpio_reg,
  input  logic [DAC_W-1:0] dac_a_code,
  input  logic [DAC_W-1:0] dac_b_code,
  output logic [7:0]       fault_reg,
  output logic             fault_pin_en,
  output logic             blast_active,
  output logic [3:0]       gpio_pd,
  output logic [DAC_W-1:0] dac_a_drive,
  output logic [DAC_W-1:0] dac_b_drive
);

  localparam int unsigned WD_W = $clog2(TIMEOUT_TICKS + 1);
  localparam int unsigned BL_W = $clog2(BLINK_HALF_TICKS + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT_TICKS - 1);
  localparam logic [BL_W-1:0] BL_LAST = BL_W'(BLINK_HALF_TICKS - 1);

  logic            init_q;
  logic            pin_q;
  logic [WD_W-1:0] wd_cnt;
  logic [BL_W-1:0] bl_cnt;
  logic            bl_phase;
  logic [3:0]      gpio_ref;

  logic       pin_blast;
  logic       wd_run;
  logic       wd_hit;
  logic [3:0] gpio_chg;

  assign pin_blast = (init_q & blast_pin) | (pin_q & ~blast_pin);
  assign wd_run    = tick & blast_pin & ~access_pulse;
  assign wd_hit    = wd_run & (wd_cnt == WD_LAST);
  assign gpio_chg  = gpio_flt_en & (gpio_pin ^ gpio_ref);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      pin_q  <= 1'b0;
      wd_cnt <= '0;
    end else begin
      init_q <= 1'b0;
      pin_q  <= blast_pin;
      if (!blast_pin || access_pulse || wd_hit)
        wd_cnt <= '0;
      else if (tick)
        wd_cnt <= wd_cnt + WD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_cnt   <= '0;
      bl_phase <= 1'b1;
    end else if (tick) begin
      if (bl_cnt == BL_LAST) begin
        bl_cnt   <= '0;
        bl_phase <= ~bl_phase;
      end else begin
        bl_cnt <= bl_cnt + BL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_reg    <= 8'h00;
      blast_active <= 1'b0;
      gpio_ref     <= 4'h0;
    end else if (fault_wr) begin
      fault_reg    <= 8'h00;
      blast_active <= 1'b0;
      gpio_ref     <= gpio_pin;
    end else begin
      fault_reg    <= fault_reg | {tach_ovf, pin_blast, wd_hit, gpio_chg};
      blast_active <= blast_active | pin_blast | wd_hit;
      gpio_ref     <= (gpio_ref & gpio_flt_en) | (gpio_pin & ~gpio_flt_en);
    end
  end

  assign fault_pin_en = ~rst_n | (|fault_reg);
  assign gpio_pd      = ~gpio_reg & (~gpio_blink_en | {4{bl_phase}});
  assign dac_a_drive  = blast_active ? {DAC_W{1'b1}} : dac_a_code;
  assign dac_b_drive  = blast_active ? {DAC_W{1'b1}} : dac_b_code;

  p_clear_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_wr |=> (fault_reg == 8'h00) && !blast_active);

  p_fall_blast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blast_pin) && !init_q && !fault_wr |=> blast_active && fault_reg[5]);

  p_timer_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_reg[4]) |-> $past(blast_pin));

  p_tach_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_wr && (tach_ovf != 2'b00) |=> ((fault_reg[7:6] & $past(tach_ovf)) == $past(tach_ovf)));

  p_gpio_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_flt_en == 4'h0) && !fault_wr |=> ((fault_reg[3:0] & ~$past(fault_reg[3:0])) == 4'h0));

endmodule

// File: tb/fan_fault_supervisor_tb.sv
module fan_fault_supervisor_tb;
  localparam int TO = 12;
  localparam int BH = 5;

  logic clk = 1'b0;
  logic rst_n, tick, blast_pin, access_pulse, fault_wr;
  logic [1:0] tach_ovf;
  logic [3:0] gpio_pin, gpio_flt_en, gpio_blink_en, gpio_reg;
  logic [7:0] dac_a_code, dac_b_code;
  logic [7:0] fault_reg;
  logic fault_pin_en, blast_active;
  logic [3:0] gpio_pd;
  logic [7:0] dac_a_drive, dac_b_drive;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  fan_fault_supervisor #(.TIMEOUT_TICKS(TO), .BLINK_HALF_TICKS(BH), .DAC_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .blast_pin(blast_pin),
    .access_pulse(access_pulse), .fault_wr(fault_wr), .tach_ovf(tach_ovf),
    .gpio_pin(gpio_pin), .gpio_flt_en(gpio_flt_en), .gpio_blink_en(gpio_blink_en),
    .gpio_reg(gpio_reg), .dac_a_code(dac_a_code), .dac_b_code(dac_b_code),
    .fault_reg(fault_reg), .fault_pin_en(fault_pin_en), .blast_active(blast_active),
    .gpio_pd(gpio_pd), .dac_a_drive(dac_a_drive), .dac_b_drive(dac_b_drive));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] next_fault(input logic [7:0] f, input logic wr,
                                            input logic [1:0] ovf, input logic [3:0] en,
                                            input logic [3:0] pin, input logic [3:0] ref_v);
    if (wr) return 8'h00;
    return f | {ovf, 2'b00, en & (pin ^ ref_v)};
  endfunction

  function automatic logic [3:0] next_ref(input logic wr, input logic [3:0] en,
                                          input logic [3:0] pin, input logic [3:0] ref_v);
    if (wr) return pin;
    return (ref_v & en) | (pin & ~en);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (no requirement) actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] mf, nf;
    logic [3:0] mref, nref;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; tick = 0; blast_pin = 0; access_pulse = 0; fault_wr = 0;
    tach_ovf = 0; gpio_pin = 0; gpio_flt_en = 0; gpio_blink_en = 0; gpio_reg = 4'hF;
    dac_a_code = 8'h3C; dac_b_code = 8'hA5;
    repeat (3) step();
    chk("R9 fault pin during reset", fault_pin_en, 1);
    chk("R1 fault reg during reset", fault_reg, 8'h00);
    rst_n = 1;
    step(); step();
    chk("R1 fault reg after reset", fault_reg, 8'h00);
    chk("R1 blast after reset", blast_active, 0);
    chk("R9 fault pin idle", fault_pin_en, 0);
    chk("R5 dac a passthrough", dac_a_drive, 8'h3C);
    chk("R5 dac b passthrough", dac_b_drive, 8'hA5);

    // R4 falling edge blast
    blast_pin = 1; step(); step();
    chk("R4 rising edge no blast", blast_active, 0);
    blast_pin = 0; step();
    chk("R4 blast on fall", blast_active, 1);
    chk("R4 blast fault bit", fault_reg, 8'h20);
    chk("R5 dac a full scale", dac_a_drive, 8'hFF);
    chk("R5 dac b full scale", dac_b_drive, 8'hFF);
    chk("R9 fault pin on fault", fault_pin_en, 1);
    fault_wr = 1; step(); fault_wr = 0;
    chk("R2 clear faults", fault_reg, 8'h00);
    chk("R2 clear blast", blast_active, 0);
    chk("R5 dac a restored", dac_a_drive, 8'h3C);
    step();
    chk("R2 stays clear", fault_reg, 8'h00);

    // R6 watchdog with restart
    blast_pin = 1; access_pulse = 1; step(); access_pulse = 0;
    tick = 1;
    repeat (TO - 2) step();
    access_pulse = 1; step(); access_pulse = 0;
    repeat (TO - 1) step();
    chk("R6 no timeout one tick early after restart", fault_reg[4], 0);
    step();
    chk("R6 timeout fault", fault_reg, 8'h10);
    chk("R6 timeout blast", blast_active, 1);
    tick = 0; blast_pin = 0; step();
    fault_wr = 1; step(); fault_wr = 0;
    chk("R2 clear after timeout", fault_reg, 8'h00);
    tick = 1;
    repeat (TO + 3) step();
    tick = 0;
    chk("R6 no timeout with pin low", fault_reg, 8'h00);

    // R7 tach latch and relatch
    tach_ovf = 2'b10; step(); tach_ovf = 0; step();
    chk("R7 tach A latched", fault_reg, 8'h80);
    tach_ovf = 2'b01; fault_wr = 1; step(); fault_wr = 0;
    chk("R7 cleared with request held", fault_reg, 8'h00);
    step();
    chk("R7 tach B relatched", fault_reg, 8'h40);
    tach_ovf = 0; fault_wr = 1; step(); fault_wr = 0; step();

    // R8 gpio change faults
    gpio_pin = 4'b0101; step(); gpio_pin = 4'b1010; step();
    chk("R8 disabled change ignored", fault_reg, 8'h00);
    gpio_flt_en = 4'b1000; step();
    chk("R8 enable alone no fault", fault_reg, 8'h00);
    gpio_pin = 4'b0010; step();
    chk("R8 change after enable", fault_reg, 8'h08);
    gpio_pin = 4'b1010; step();
    chk("R8 fault held", fault_reg, 8'h08);
    fault_wr = 1; step(); fault_wr = 0;
    chk("R8 cleared", fault_reg, 8'h00);
    step();
    chk("R8 unchanged since clear", fault_reg, 8'h00);
    gpio_pin = 4'b0010; step();
    chk("R8 change from clear state", fault_reg, 8'h08);

    // random tach / gpio / clear mix
    fault_wr = 1; step(); fault_wr = 0;
    mf = 8'h00; mref = gpio_pin;
    for (int i = 0; i < 400; i++) begin
      tach_ovf    = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
      gpio_pin    = (($urandom % 4) == 0) ? 4'($urandom) : gpio_pin;
      gpio_flt_en = (($urandom % 8) == 0) ? 4'($urandom) : gpio_flt_en;
      fault_wr    = (($urandom % 8) == 0);
      nf   = next_fault(mf, fault_wr, tach_ovf, gpio_flt_en, gpio_pin, mref);
      nref = next_ref(fault_wr, gpio_flt_en, gpio_pin, mref);
      step();
      mf = nf; mref = nref;
      chk("R7 random tach bits", fault_reg[7:6], mf[7:6]);
      chk("R8 random gpio bits", fault_reg[3:0], mf[3:0]);
      chk("R2 random no blast bits", fault_reg[5:4], 2'b00);
      chk("R9 random fault pin", fault_pin_en, |mf);
    end
    tach_ovf = 0; gpio_flt_en = 0; fault_wr = 1; step(); fault_wr = 0;

    // R3 blast at reset release, R10 blink
    rst_n = 0; blast_pin = 1; gpio_reg = 4'b1010; gpio_blink_en = 4'b0100;
    step(); step();
    rst_n = 1; step(); step();
    chk("R3 blast at reset release", blast_active, 1);
    chk("R3 blast bit at reset release", fault_reg, 8'h20);
    chk("R5 dac b full scale at start", dac_b_drive, 8'hFF);
    chk("R10 blink starts on", gpio_pd, 4'b0101);
    tick = 1;
    repeat (BH - 1) step();
    chk("R10 phase held before period", gpio_pd, 4'b0101);
    step();
    chk("R10 phase toggled", gpio_pd, 4'b0001);
    repeat (BH) step();
    chk("R10 phase back on", gpio_pd, 4'b0101);
    tick = 0; gpio_reg = 4'hF; step();
    chk("R10 register high releases", gpio_pd, 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule